// File: doc/BRIEF.md
# Two-Arm Traffic Phase Controller

This block drives the signal heads at a crossing of two arms that share a pedestrian crossing. It steps through eleven phases held in a 4-bit state register. Each arm in turn gets green, then yellow, then a protected turn, then yellow again, and then returns to red. An all-red gap separates every change of right of way. When a pedestrian has asked to cross, a walk phase and a blinking phase follow an all-red gap. During both of them the two arms stay red.

Each phase lasts for a number of timer ticks. A 4-bit dwell accumulator counts these ticks and restarts at zero whenever the phase changes. A comparator checks the count against one of four delay constants, and a multiplexer chooses that constant from the current phase. A switch input can end a green early, but only after a minimum green time. A single-cycle completion pulse tells a companion flow-control unit that an arm has given up its right of way. The state, the next state and the dwell count are brought out so that the block can be observed.

Top module: `traffic_phase_ctrl`

## Requirements
- R1: While `clr` is high at a rising edge, the next cycle shows state 0 (all-red), both light codes 0, `walk` low, `complete` low and a dwell count of 0.
- R2: Light codes are 0 red, 1 yellow, 2 green, 3 turn. An arm that has right of way shows 2, 1, 3, 1 and then 0. Meanwhile the other arm shows 0.
- R3: A phase lasts one cycle longer than its delay. With the default delays this gives: all-red and yellow 3 cycles (yellow-to-red = 2), turn and blink 6 cycles (blink = 5), walk 11 cycles (walk = 10), and green 16 cycles (maximum green = 15) when `sw` stays low.
- R4: When `sw` is high in a green phase whose dwell count has reached the minimum green (default 4), the phase ends at that edge. With `sw` held high, a green lasts 5 cycles.
- R5: The arms take turns. The first arm to get green after a clear is arm B if `arm_sel` was 1 during the clear, and arm A otherwise.
- R6: A one-cycle `ped_req` is held until it is served. Service happens at the next exit from all-red, which then goes to the walk phase (state 9) rather than to an arm. Both arms are 0 during walk and blink.
- R7: `walk` is high for the whole walk phase. In the blink phase (state 10), `walk` equals bit 0 of the dwell count, so it starts low and toggles on every tick.
- R8: `complete` is high for exactly one cycle: the first cycle after an arm's final yellow phase (state 4 or 8) ends.
- R9: The dwell count goes to 0 in the first cycle of a new phase. Otherwise it increases by one per cycle, and it saturates at 15. `dwell_done` is high when the count equals the delay chosen for the current phase.
- R10: The state encoding is 0 all-red, 1–4 arm A green/yellow/turn/yellow, 5–8 the same for arm B, 9 walk, 10 blink. `state_nx` shows the value that the state takes at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| clr | input | 1 | Synchronous clear |
| ped_req | input | 1 | Pedestrian crossing request |
| arm_sel | input | 1 | Arm that gets green first after a clear (0 = A, 1 = B) |
| sw | input | 1 | Asks to end the current green early |
| arm_a_light | output | 2 | Light code of arm A |
| arm_b_light | output | 2 | Light code of arm B |
| walk | output | 1 | Pedestrian walk indication |
| complete | output | 1 | One-cycle pulse when an arm's phase is finished |
| state_q | output | 4 | Current phase |
| state_nx | output | 4 | Next phase |
| dwell_cnt | output | 4 | Dwell accumulator |
| dwell_done | output | 1 | Count equals the selected delay |

## Verification
The sequencer is first run with `sw` low, so every green reaches maximum green and the full alternation between the arms is visible. Next, `sw` is held high so that green is cut at the minimum. This separates the early-exit path from the maximum-green comparison. A single-cycle pedestrian pulse shows whether the request is latched and whether walk and blink replace an arm turn. A clear with `arm_sel` high shows whether the first arm can be chosen.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [3:0] {
    PH_ALLRED = 4'd0,
    PH_A_GRN  = 4'd1,
    PH_A_YL1  = 4'd2,
    PH_A_TRN  = 4'd3,
    PH_A_YL2  = 4'd4,
    PH_B_GRN  = 4'd5,
    PH_B_YL1  = 4'd6,
    PH_B_TRN  = 4'd7,
    PH_B_YL2  = 4'd8,
    PH_WALK   = 4'd9,
    PH_BLINK  = 4'd10
  } phase_e;

  localparam int NUM_PHASES = 11;
  localparam int PHASES_PER_ARM = 4;

  typedef enum logic [1:0] {
    LT_RED = 2'd0,
    LT_YEL = 2'd1,
    LT_GRN = 2'd2,
    LT_TRN = 2'd3
  } light_e;

  typedef enum logic [1:0] {
    DS_CLEAR = 2'd0,
    DS_WALK  = 2'd1,
    DS_BLINK = 2'd2,
    DS_GREEN = 2'd3
  } dsel_e;

  // which delay constant governs a phase
  function automatic dsel_e dsel_of(input phase_e p);
    case (p)
      PH_A_GRN, PH_B_GRN:             dsel_of = DS_GREEN;
      PH_A_TRN, PH_B_TRN, PH_BLINK:   dsel_of = DS_BLINK;
      PH_WALK:                        dsel_of = DS_WALK;
      default:                        dsel_of = DS_CLEAR;
    endcase
  endfunction

  // light code for the k-th phase (0..3) of an arm's own sequence
  function automatic light_e head_of_step(input int unsigned k);
    case (k)
      0:       head_of_step = LT_GRN;
      2:       head_of_step = LT_TRN;
      default: head_of_step = LT_YEL;
    endcase
  endfunction

  // saturating increment of the dwell accumulator
  function automatic logic [3:0] sat_inc(input logic [3:0] v);
    sat_inc = (v == 4'hF) ? v : v + 4'd1;
  endfunction

endpackage

// File: rtl/tpc_decoder.sv
module tpc_decoder
  import tpc_pkg::*;
#(
  parameter int SW_BITS = 4,
  parameter int LINES   = NUM_PHASES
) (
  input  logic [SW_BITS-1:0] state,
  output logic [LINES-1:0]   lines
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = (state == SW_BITS'(i));
  end
endmodule

// File: rtl/tpc_dwell_timer.sv
module tpc_dwell_timer
  import tpc_pkg::*;
#(
  parameter int CW       = 4,
  parameter int T_CLEAR  = 2,
  parameter int T_WALK   = 10,
  parameter int T_BLINK  = 5,
  parameter int T_MAXGRN = 15
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          restart,
  input  dsel_e         dsel,
  output logic [CW-1:0] cnt,
  output logic          done
);
  localparam logic [CW-1:0] THR [4] = '{CW'(T_CLEAR), CW'(T_WALK),
                                        CW'(T_BLINK), CW'(T_MAXGRN)};
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] thr;

  always_comb thr = THR[dsel];

  assign done = (cnt == thr);

  always_ff @(posedge clk) begin
    if (clr || restart) cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/tpc_phase_fsm.sv
module tpc_phase_fsm
  import tpc_pkg::*;
#(
  parameter int CW       = 4,
  parameter int T_MINGRN = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          ped_req,
  input  logic          arm_sel,
  input  logic          sw,
  input  logic [CW-1:0] cnt,
  input  logic          done,
  output phase_e        state,
  output phase_e        state_nx,
  output logic          phase_change,
  output logic          complete
);
  logic ped_pend;
  logic next_is_b;
  logic in_green;
  logic early_exit;
  logic leave;
  logic arm_finish;

  assign in_green   = (state == PH_A_GRN) || (state == PH_B_GRN);
  assign early_exit = in_green && sw && (cnt >= CW'(T_MINGRN));
  assign leave      = done || early_exit;
  assign arm_finish = leave && ((state == PH_A_YL2) || (state == PH_B_YL2));

  always_comb begin
    state_nx = state;
    if (leave) begin
      case (state)
        PH_ALLRED: state_nx = ped_pend ? PH_WALK : (next_is_b ? PH_B_GRN : PH_A_GRN);
        PH_A_GRN:  state_nx = PH_A_YL1;
        PH_A_YL1:  state_nx = PH_A_TRN;
        PH_A_TRN:  state_nx = PH_A_YL2;
        PH_B_GRN:  state_nx = PH_B_YL1;
        PH_B_YL1:  state_nx = PH_B_TRN;
        PH_B_TRN:  state_nx = PH_B_YL2;
        PH_WALK:   state_nx = PH_BLINK;
        default:   state_nx = PH_ALLRED;
      endcase
    end
    if (state > PH_BLINK) state_nx = PH_ALLRED;
  end

  assign phase_change = (state_nx != state);

  always_ff @(posedge clk) begin
    if (clr) begin
      state     <= PH_ALLRED;
      ped_pend  <= 1'b0;
      next_is_b <= arm_sel;
      complete  <= 1'b0;
    end else begin
      state    <= state_nx;
      complete <= arm_finish;
      ped_pend <= (ped_pend && !(state_nx == PH_WALK && state != PH_WALK)) || ped_req;
      if (arm_finish) next_is_b <= (state == PH_A_YL2);
    end
  end
endmodule

// File: rtl/traffic_phase_ctrl.sv
module traffic_phase_ctrl
  import tpc_pkg::*;
#(
  parameter int CW       = 4,
  parameter int T_CLEAR  = 2,
  parameter int T_WALK   = 10,
  parameter int T_BLINK  = 5,
  parameter int T_MAXGRN = 15,
  parameter int T_MINGRN = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ped_req,
  input  logic         arm_sel,
  input  logic         sw,
  output logic [1:0]   arm_a_light,
  output logic [1:0]   arm_b_light,
  output logic         walk,
  output logic         complete,
  output logic [3:0]   state_q,
  output logic [3:0]   state_nx,
  output logic [CW-1:0] dwell_cnt,
  output logic         dwell_done
);
  localparam int NUM_ARMS = 2;

  phase_e              st;
  phase_e              st_nx;
  logic                phase_change;
  logic [NUM_PHASES-1:0] dec_lines;
  logic [1:0]          heads [NUM_ARMS];

  tpc_phase_fsm #(.CW(CW), .T_MINGRN(T_MINGRN)) u_fsm (
    .clk(clk), .clr(clr), .ped_req(ped_req), .arm_sel(arm_sel), .sw(sw),
    .cnt(dwell_cnt), .done(dwell_done),
    .state(st), .state_nx(st_nx), .phase_change(phase_change),
    .complete(complete)
  );

  tpc_dwell_timer #(.CW(CW), .T_CLEAR(T_CLEAR), .T_WALK(T_WALK),
                    .T_BLINK(T_BLINK), .T_MAXGRN(T_MAXGRN)) u_timer (
    .clk(clk), .clr(clr), .restart(phase_change), .dsel(dsel_of(st)),
    .cnt(dwell_cnt), .done(dwell_done)
  );

  tpc_decoder #(.SW_BITS(4), .LINES(NUM_PHASES)) u_dec (
    .state(st), .lines(dec_lines)
  );

  for (genvar a = 0; a < NUM_ARMS; a++) begin : g_arm
    localparam int BASE = 1 + a * PHASES_PER_ARM;
    always_comb begin
      heads[a] = LT_RED;
      for (int k = 0; k < PHASES_PER_ARM; k++)
        if (dec_lines[BASE + k]) heads[a] = head_of_step(k);
    end
  end

  assign arm_a_light = heads[0];
  assign arm_b_light = heads[1];
  assign walk        = dec_lines[PH_WALK] || (dec_lines[PH_BLINK] && dwell_cnt[0]);
  assign state_q     = st;
  assign state_nx    = st_nx;
endmodule

// File: rtl/traffic_phase_ctrl_chk.sv
module traffic_phase_ctrl_chk (
  input logic        clk,
  input logic        clr,
  input logic [1:0]  arm_a_light,
  input logic [1:0]  arm_b_light,
  input logic        walk,
  input logic        complete,
  input logic [3:0]  state_q,
  input logic [3:0]  state_nx,
  input logic [3:0]  dwell_cnt,
  input logic [10:0] dec_lines
);
  a_r1_clear_state: assert property (@(posedge clk)
    clr |=> (state_q == 4'd0 && dwell_cnt == 4'd0 && !complete && !walk));

  a_r2_one_arm_moving: assert property (@(posedge clk) disable iff (clr)
    (arm_a_light != 2'd0) |-> (arm_b_light == 2'd0));

  a_r6_walk_from_allred: assert property (@(posedge clk) disable iff (clr)
    (state_q != 4'd9) ##1 (state_q == 4'd9) |-> ($past(state_q) == 4'd0));

  a_r7_walk_arms_red: assert property (@(posedge clk) disable iff (clr)
    walk |-> (arm_a_light == 2'd0 && arm_b_light == 2'd0));

  a_r8_complete_single: assert property (@(posedge clk) disable iff (clr)
    complete |=> !complete);

  a_r8_complete_after_yellow: assert property (@(posedge clk) disable iff (clr)
    $rose(complete) |-> (state_q == 4'd0));

  a_r9_restart_on_change: assert property (@(posedge clk) disable iff (clr)
    (state_nx != state_q) |=> (dwell_cnt == 4'd0));

  a_r10_next_taken: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> (state_q == $past(state_nx)));

  a_r10_legal_decode: assert property (@(posedge clk) disable iff (clr)
    $countones(dec_lines) == 1);
endmodule

bind traffic_phase_ctrl traffic_phase_ctrl_chk u_chk (
  .clk(clk), .clr(clr), .arm_a_light(arm_a_light), .arm_b_light(arm_b_light),
  .walk(walk), .complete(complete), .state_q(state_q), .state_nx(state_nx),
  .dwell_cnt(dwell_cnt), .dec_lines(dec_lines)
);

// File: tb/sim_traffic_phase_ctrl.sv
`timescale 1ns/1ps
module sim_traffic_phase_ctrl;
  localparam int D_CLR = 2, D_WALK = 10, D_BLINK = 5, D_MAX = 15, D_MIN = 4;

  logic clk = 1'b0, clr = 1'b1, ped_req = 1'b0, arm_sel = 1'b0, sw = 1'b0;
  logic [1:0] arm_a_light, arm_b_light;
  logic walk, complete, dwell_done;
  logic [3:0] state_q, state_nx, dwell_cnt;

  traffic_phase_ctrl u0 (
    .clk(clk), .clr(clr), .ped_req(ped_req), .arm_sel(arm_sel), .sw(sw),
    .arm_a_light(arm_a_light), .arm_b_light(arm_b_light), .walk(walk),
    .complete(complete), .state_q(state_q), .state_nx(state_nx),
    .dwell_cnt(dwell_cnt), .dwell_done(dwell_done)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  // reference model: phase number, ticks spent, pending request, arm owed next
  int ms = 0, mc = 0, mp = 0, mnb = 0, mcomp = 0;
  int lim, nx;
  bit leave;
  // observation for directed checks
  int a_run = 0, last_a_grn = 0, walk_run = 0, max_walk = 0;
  bit saw_served = 0;

  function automatic int delay_for(int ph);
    if (ph == 9) return D_WALK;
    if (ph == 10 || ph == 3 || ph == 7) return D_BLINK;
    if (ph == 1 || ph == 5) return D_MAX;
    return D_CLR;
  endfunction

  function automatic int code_for(int ph, int arm);
    int k;
    k = ph - 1 - 4 * arm;
    if (k < 0 || k > 3) return 0;
    if (k == 0) return 2;
    if (k == 2) return 3;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (clr) begin
      ms = 0; mc = 0; mp = 0; mnb = int'(arm_sel); mcomp = 0;
    end else begin
      lim   = delay_for(ms);
      leave = (mc == lim) || ((ms == 1 || ms == 5) && sw && mc >= D_MIN);
      nx    = ms;
      if (leave) begin
        if (ms == 0) nx = mp ? 9 : (mnb ? 5 : 1);
        else if (ms == 4 || ms == 8 || ms == 10) nx = 0;
        else nx = ms + 1;
      end
      mcomp = (leave && (ms == 4 || ms == 8)) ? 1 : 0;
      if (leave && ms == 4) mnb = 1;
      if (leave && ms == 8) mnb = 0;
      if (nx == 9 && ms != 9) mp = 0;
      if (ped_req) mp = 1;
      mc = (nx != ms) ? 0 : (mc < 15 ? mc + 1 : 15);
      ms = nx;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    int ew;
    @(negedge clk);
    ew = (ms == 9) ? 1 : (ms == 10) ? (mc % 2) : 0;
    chk(int'(arm_a_light) == code_for(ms, 0), "R2 arm A", arm_a_light, code_for(ms, 0));
    chk(int'(arm_b_light) == code_for(ms, 1), "R2 arm B", arm_b_light, code_for(ms, 1));
    chk(int'(walk) == ew, "R7 walk", walk, ew);
    chk(int'(complete) == mcomp, "R8 complete", complete, mcomp);
    chk(int'(state_q) == ms, "R10 state", state_q, ms);
    chk(int'(dwell_cnt) == mc, "R9 dwell count", dwell_cnt, mc);
    chk(dwell_done == (mc == delay_for(ms)), "R9 dwell done", dwell_done, mc == delay_for(ms));
    if (arm_a_light == 2'd2) a_run++;
    else if (a_run > 0) begin last_a_grn = a_run; a_run = 0; end
    if (walk && state_q == 4'd9) walk_run++;
    else begin if (walk_run > max_walk) max_walk = walk_run; walk_run = 0; end
    if (state_q == 4'd9 && arm_a_light == 0 && arm_b_light == 0) saw_served = 1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_clear(bit sel);
    clr = 1'b1; arm_sel = sel;
    run(2);
    clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: clear state
    do_clear(1'b0);
    chk(state_q == 4'd0 && arm_a_light == 0 && arm_b_light == 0 && !walk && dwell_cnt == 0,
        "R1 clear", state_q, 0);
    // R3: green runs to maximum with sw low; R5 arms alternate
    run(140);
    chk(last_a_grn == D_MAX + 1, "R3 green length", last_a_grn, D_MAX + 1);
    // R4: early exit with sw held
    do_clear(1'b0);
    last_a_grn = 0; a_run = 0;
    sw = 1'b1;
    run(40);
    chk(last_a_grn == D_MIN + 1, "R4 early green length", last_a_grn, D_MIN + 1);
    sw = 1'b0;
    // R6: single-cycle request latched and served
    ped_req = 1'b1; step(); ped_req = 1'b0;
    run(90);
    chk(saw_served, "R6 walk served", saw_served, 1);
    chk(max_walk == D_WALK + 1, "R7 walk length", max_walk, D_WALK + 1);
    // R5: arm_sel chooses the first arm
    do_clear(1'b1);
    run(D_CLR + 2);
    chk(arm_b_light == 2'd2 && arm_a_light == 2'd0, "R5 first arm B", arm_b_light, 2);
    run(60);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule